// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a small console peripheral on a word-addressed load/store bus. It has a receive side, which takes characters from a keyboard-style byte source, and a transmit side, which hands characters to a display-style sink. Each side shows software two 32-bit words: a control word and a data word. Software can poll the control words for readiness, or it can enable interrupts so that a ready condition raises a request line.

Software moves data through loads and stores. A load from the receive data word returns the latest character and marks it as consumed. A store to the transmit data word starts a transfer to the display. The transmit side then reports busy until the display acknowledges that it has finished. A sticky flag records a character that was overwritten before software read it.

Top module: `ttyPort`

## Requirements
- R1: After reset, the receive control word reads 0 and the transmit control word reads 1 (transmitter ready, both interrupt enables clear). The irq output is 0 and dispSend is 0.
- R2: The four words sit at BASE_ADDR + 0x0 (receive control), + 0x4 (receive data), + 0x8 (transmit control) and + 0xC (transmit data). An access whose address lies outside this 16-byte window reads 0, and a write to such an address changes nothing.
- R3: A cycle with kbdValid high stores kbdData and sets receive Ready, bit 0 of the receive control word. The receive data word returns that character in bits 7:0 and zero in every bit above them.
- R4: A load from the receive data word clears receive Ready and the overrun flag.
- R5: A character that arrives while receive Ready is 1, with no load of the receive data word in the same cycle, replaces the stored character and sets the sticky overrun flag, bit 2 of the receive control word.
- R6: In both control words, bit 1 is a read/write interrupt enable and bit 0 (Ready) is read-only. All bits above bit 2 read 0, and bit 2 of the transmit control word always reads 0.
- R7: A store to the transmit data word while transmit Ready is 1 latches bits 7:0 onto dispData and pulses dispSend high for exactly the following cycle. Transmit Ready then reads 0 until dispDone is sampled high. The transmit data word reads back the last character that was accepted.
- R8: A store to the transmit data word while transmit Ready is 0 is ignored: no dispSend pulse, and dispData and the transmit data word keep their values.
- R9: irq is a register. It goes high one cycle after (receive Ready AND receive enable) OR (transmit Ready AND transmit enable) becomes true, and it goes low one cycle after that condition becomes false.
- R10: busRdata is updated on the clock edge that samples busRd and holds its value until the next read.
- R11: When a load of the receive data word and an arriving character fall in the same cycle, the load returns the old character. Ready stays 1 holding the new character, and the overrun flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busRd | input | 1 | Load strobe |
| busWr | input | 1 | Store strobe |
| busWdata | input | DATA_W | Store data |
| busRdata | output | DATA_W | Load data, valid from the cycle after busRd |
| kbdData | input | CHAR_W | Incoming character |
| kbdValid | input | 1 | Incoming character strobe |
| dispData | output | CHAR_W | Character being sent to the display |
| dispSend | output | 1 | One-cycle start pulse to the display |
| dispDone | input | 1 | Display finished with the current character |
| irq | output | 1 | Registered level interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit address and data bus, 8-bit characters and a base of 0xFFFF0000. These widths make the zero-fill above the character byte visible, along with the unused high control bits. The 16-byte window can be probed from both sides with real addresses just below and just above it. The display model's acknowledge delay is a bench variable. Stretching it holds the transmitter busy long enough to issue a store that must be dropped, and it lets the interrupt level follow both sides.

// File: rtl/ttyPkg.sv
`timescale 1ns/1ps
package ttyPkg;

  localparam int READY_BIT = 0;
  localparam int IE_BIT    = 1;
  localparam int OVR_BIT   = 2;
  localparam int REG_COUNT = 4;

  // word index inside the window; the order is the bus map
  typedef enum logic [1:0] {
    SEL_RX_CTL = 2'd0,
    SEL_RX_DAT = 2'd1,
    SEL_TX_CTL = 2'd2,
    SEL_TX_DAT = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    rdHit;
    logic    rdMiss;
    regSel_e rdSel;
    logic    captureRx;
    logic    loadTx;
  } dpStrobe_t;

  // flag state owned by control, shown on readback
  typedef struct packed {
    logic rxReady;
    logic rxIe;
    logic rxOverrun;
    logic txReady;
    logic txIe;
  } ctlState_t;

endpackage

// File: rtl/ttyCtrl.sv
`timescale 1ns/1ps
module ttyCtrl
  import ttyPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000,
  localparam int IDX_LSB = $clog2(DATA_W / 8),
  localparam int WIN_LSB = IDX_LSB + $clog2(REG_COUNT)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:IDX_LSB] wordAddr,
  input  logic                    busRd,
  input  logic                    busWr,
  input  logic                    ieIn,
  input  logic                    kbdValid,
  input  logic                    dispDone,
  output dpStrobe_t               strobe,
  output ctlState_t               state,
  output logic                    dispSend,
  output logic                    irq
);

  logic    inWindow;
  regSel_e sel;
  logic    rdRxDat;
  logic    wrRxCtl, wrTxCtl, wrTxDat;
  logic    rxReady, rxIe, rxOverrun;
  logic    txBusy, txIe;
  logic    loadTx;

  // address decode
  assign inWindow = (wordAddr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
  assign sel      = regSel_e'(wordAddr[WIN_LSB-1:IDX_LSB]);

  assign rdRxDat = busRd && inWindow && (sel == SEL_RX_DAT);
  assign wrRxCtl = busWr && inWindow && (sel == SEL_RX_CTL);
  assign wrTxCtl = busWr && inWindow && (sel == SEL_TX_CTL);
  assign wrTxDat = busWr && inWindow && (sel == SEL_TX_DAT);

  assign loadTx = wrTxDat && !txBusy;

  always_comb begin
    strobe.rdHit     = busRd && inWindow;
    strobe.rdMiss    = busRd && !inWindow;
    strobe.rdSel     = sel;
    strobe.captureRx = kbdValid;
    strobe.loadTx    = loadTx;
  end

  // receive flags: an arriving character wins over the read side effect
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady   <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (kbdValid)     rxReady <= 1'b1;
      else if (rdRxDat) rxReady <= 1'b0;

      if (kbdValid && rxReady && !rdRxDat) rxOverrun <= 1'b1;
      else if (rdRxDat)                    rxOverrun <= 1'b0;
    end
  end

  // interrupt enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIe <= 1'b0;
      txIe <= 1'b0;
    end else begin
      if (wrRxCtl) rxIe <= ieIn;
      if (wrTxCtl) txIe <= ieIn;
    end
  end

  // transmit handshake
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy   <= 1'b0;
      dispSend <= 1'b0;
    end else begin
      dispSend <= loadTx;
      if (loadTx)        txBusy <= 1'b1;
      else if (dispDone) txBusy <= 1'b0;
    end
  end

  always_comb begin
    state.rxReady   = rxReady;
    state.rxIe      = rxIe;
    state.rxOverrun = rxOverrun;
    state.txReady   = !txBusy;
    state.txIe      = txIe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) irq <= 1'b0;
    else       irq <= (rxReady && rxIe) || (!txBusy && txIe);
  end

  // checks next to the logic
  p_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    kbdValid |=> rxReady);
  p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdRxDat && !kbdValid) |=> (!rxReady && !rxOverrun));
  p_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    (kbdValid && rxReady && !rdRxDat) |=> rxOverrun);
  p_send_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    dispSend |=> (!dispSend && (txBusy || $past(dispDone))));
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrTxDat && txBusy) |=> !dispSend);
  p_irq_rx_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && rxIe) |=> irq);
  p_irq_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!(rxReady && rxIe) && !(!txBusy && txIe)) |=> !irq);
  p_win_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrRxCtl, wrTxCtl, wrTxDat}));

endmodule

// File: rtl/ttyDatapath.sv
`timescale 1ns/1ps
module ttyDatapath
  import ttyPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  ctlState_t         state,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic [CHAR_W-1:0] txIn,
  output logic [CHAR_W-1:0] dispData,
  output logic [DATA_W-1:0] busRdata
);

  logic [CHAR_W-1:0] rxChar;
  logic [CHAR_W-1:0] txChar;
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rxCtlWord, txCtlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxChar <= '0;
      txChar <= '0;
    end else begin
      if (strobe.captureRx) rxChar <= kbdData;
      if (strobe.loadTx)    txChar <= txIn;
    end
  end

  assign dispData = txChar;

  // control words built bit by bit; unlisted bits stay zero
  always_comb begin
    rxCtlWord            = '0;
    rxCtlWord[READY_BIT] = state.rxReady;
    rxCtlWord[IE_BIT]    = state.rxIe;
    rxCtlWord[OVR_BIT]   = state.rxOverrun;
    txCtlWord            = '0;
    txCtlWord[READY_BIT] = state.txReady;
    txCtlWord[IE_BIT]    = state.txIe;
  end

  always_comb begin
    word = '0;
    unique case (strobe.rdSel)
      SEL_RX_CTL: word = rxCtlWord;
      SEL_RX_DAT: word[CHAR_W-1:0] = rxChar;
      SEL_TX_CTL: word = txCtlWord;
      SEL_TX_DAT: word[CHAR_W-1:0] = txChar;
      default:    word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)              busRdata <= '0;
    else if (strobe.rdHit)  busRdata <= word;
    else if (strobe.rdMiss) busRdata <= '0;
  end

  p_rx_hi_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdHit && strobe.rdSel == SEL_RX_DAT) |=> (busRdata[DATA_W-1:CHAR_W] == '0));
  p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdMiss |=> (busRdata == '0));
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdHit || strobe.rdMiss) |=> $stable(busRdata));
  p_disp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadTx |=> $stable(dispData));

endmodule

// File: rtl/ttyPort.sv
`timescale 1ns/1ps
module ttyPort
  import ttyPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] kbdData,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispData,
  output logic              dispSend,
  input  logic              dispDone,
  output logic              irq
);

  localparam int IDX_LSB = $clog2(DATA_W / 8);

  dpStrobe_t strobe;
  ctlState_t state;
  logic      unusedBits;

  assign unusedBits = ^{busAddr[IDX_LSB-1:0], busWdata[DATA_W-1:CHAR_W]};

  ttyCtrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .wordAddr(busAddr[ADDR_W-1:IDX_LSB]),
    .busRd(busRd), .busWr(busWr),
    .ieIn(busWdata[IE_BIT]),
    .kbdValid(kbdValid), .dispDone(dispDone),
    .strobe(strobe), .state(state),
    .dispSend(dispSend), .irq(irq)
  );

  ttyDatapath #(
    .DATA_W(DATA_W), .CHAR_W(CHAR_W)
  ) uData (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .state(state),
    .kbdData(kbdData), .txIn(busWdata[CHAR_W-1:0]),
    .dispData(dispData), .busRdata(busRdata)
  );

endmodule

// File: tb/tb_ttyPort.sv
`timescale 1ns/1ps
module tb_ttyPort;

  localparam logic [31:0] BASE  = 32'hFFFF_0000;
  localparam logic [31:0] RXCTL = BASE + 32'h0;
  localparam logic [31:0] RXDAT = BASE + 32'h4;
  localparam logic [31:0] TXCTL = BASE + 32'h8;
  localparam logic [31:0] TXDAT = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRd = 1'b0, busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  kbdData = '0;
  logic        kbdValid = 1'b0;
  logic [7:0]  dispData;
  logic        dispSend;
  logic        dispDone = 1'b0;
  logic        irq;

  int checks = 0, errors = 0;
  int dispDelay = 4;
  int doneCnt = 0;
  logic rdSeen = 1'b0;
  bit finished = 1'b0;

  typedef struct { string tag; logic [31:0] val; } item_t;
  item_t rdQ[$];
  item_t dispQ[$];

  always #2.5 clk = ~clk;

  ttyPort dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .kbdData(kbdData), .kbdValid(kbdValid),
    .dispData(dispData), .dispSend(dispSend), .dispDone(dispDone), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // read monitor: pops expected load results
  always @(posedge clk) rdSeen <= busRd;
  always @(negedge clk) begin
    if (rdSeen) begin
      if (rdQ.size() == 0) chk("R10 unexpected read result", busRdata, 32'hx);
      else begin
        item_t it;
        it = rdQ.pop_front();
        chk(it.tag, busRdata, it.val);
      end
    end
  end

  // display model and monitor
  always @(negedge clk) begin
    dispDone = 1'b0;
    if (doneCnt > 0) begin
      doneCnt--;
      if (doneCnt == 0) dispDone = 1'b1;
    end
    if (dispSend) begin
      if (dispQ.size() == 0) chk("R8 unexpected dispSend", {24'h0, dispData}, 32'hx);
      else begin
        item_t it;
        it = dispQ.pop_front();
        chk(it.tag, {24'h0, dispData}, it.val);
      end
      doneCnt = dispDelay;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busRead(logic [31:0] a, logic [31:0] exp, string tag);
    rdQ.push_back('{tag, exp});
    busAddr = a; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic busWrite(logic [31:0] a, logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic keyIn(logic [7:0] c);
    kbdData = c; kbdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    kbdValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    chk("R1 dispSend after reset", {31'h0, dispSend}, 32'h0);
    busRead(RXCTL, 32'h0, "R1 rx control reset");
    busRead(TXCTL, 32'h1, "R1 tx control reset");

    // R6 control layout, R9 tx interrupt
    busWrite(TXCTL, 32'hFFFF_FFFF);
    busRead(TXCTL, 32'h3, "R6 tx control ie set, high bits zero");
    chk("R9 irq from tx ready and enable", {31'h0, irq}, 32'h1);
    busWrite(TXCTL, 32'h0);
    step(1);
    chk("R9 irq drops after tx enable cleared", {31'h0, irq}, 32'h0);
    busWrite(RXCTL, 32'hFFFF_FFFF);
    busRead(RXCTL, 32'h2, "R6 rx ready and overrun not writable");
    busWrite(RXCTL, 32'h0);

    // R3 / R4 receive path
    keyIn(8'h41);
    busRead(RXCTL, 32'h1, "R3 rx ready after char");
    busRead(RXDAT, 32'h41, "R3 rx data zero-extended");
    busRead(RXCTL, 32'h0, "R4 rx ready cleared by data read");

    // R5 overrun
    keyIn(8'h11);
    keyIn(8'h22);
    busRead(RXCTL, 32'h5, "R5 overrun flag set");
    busRead(RXDAT, 32'h22, "R5 newest char kept");
    busRead(RXCTL, 32'h0, "R4 overrun cleared by data read");

    // R9 receive interrupt
    busWrite(RXCTL, 32'h2);
    keyIn(8'h33);
    step(1);
    chk("R9 irq from rx ready and enable", {31'h0, irq}, 32'h1);
    busRead(RXDAT, 32'h33, "R9 rx data under interrupt");
    step(1);
    chk("R9 irq drops after rx read", {31'h0, irq}, 32'h0);
    busWrite(RXCTL, 32'h0);

    // R11 same-cycle read and arrival
    keyIn(8'h44);
    rdQ.push_back('{"R11 read returns old char", 32'h44});
    busAddr = RXDAT; busRd = 1'b1; kbdData = 8'h55; kbdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0; kbdValid = 1'b0;
    busRead(RXCTL, 32'h1, "R11 ready kept, no overrun");
    busRead(RXDAT, 32'h55, "R11 new char held");

    // R7 transmit
    dispDelay = 4;
    dispQ.push_back('{"R7 display char", 32'h48});
    busWrite(TXDAT, 32'h1234_5648);
    chk("R7 dispSend pulse", {31'h0, dispSend}, 32'h1);
    step(1);
    chk("R7 dispSend one cycle", {31'h0, dispSend}, 32'h0);
    busRead(TXCTL, 32'h0, "R7 tx not ready while busy");
    step(6);
    busRead(TXCTL, 32'h1, "R7 tx ready after done");
    busRead(TXDAT, 32'h48, "R7 tx data readback");

    // R8 store while busy
    dispDelay = 20;
    dispQ.push_back('{"R8 first char sent", 32'h61});
    busWrite(TXDAT, 32'h61);
    step(2);
    busWrite(TXDAT, 32'h62);
    step(1);
    chk("R8 dispData kept", {24'h0, dispData}, 32'h61);
    busRead(TXDAT, 32'h61, "R8 busy store dropped");
    // R10 hold
    step(3);
    chk("R10 read data held", busRdata, 32'h61);
    step(20);
    busRead(TXCTL, 32'h1, "R8 tx ready again");

    // R2 decode
    busRead(BASE + 32'h10, 32'h0, "R2 read above window");
    busWrite(BASE - 32'h8, 32'hFFFF_FFFF);
    busRead(TXCTL, 32'h1, "R2 write below window ignored");
    busRead(32'h0000_0004, 32'h0, "R2 read far outside window");

    step(5);
    chk("R10 read queue drained", rdQ.size(), 32'h0);
    chk("R7 display queue drained", dispQ.size(), 32'h0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule